// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This combinational block sits beside the datapath of a fused multiply-add unit that forms a*b+c, or a*b-c, in single or double precision. It looks at the three operands and decides what the result must be whenever a NaN takes part. It chooses either one of the operands, made quiet, or the default NaN. It also reports whether an invalid-operation exception must be raised. The arithmetic path, rounding and every non-NaN result lie outside it. The same selection serves add and subtract forms, so the block has no operation input.

A mode input picks one of two NaN conventions. In the legacy convention a set top mantissa bit marks a signaling NaN. In the 2008 convention a set top mantissa bit marks a quiet NaN. The mode also changes the order in which operands are searched for a NaN. It further changes what happens when infinity is multiplied by zero and the addend is a NaN.

Top module: `fmanan_sel`

## Requirements
- R1: When no operand is a NaN, including infinity times zero with a non-NaN addend, nanPresent, nanResult and invalidOp are all zero.
- R2: In single precision (isDouble=0) only bits 31:0 of each operand are examined: exponent bits 30:23, mantissa bits 22:0, quiet/signal bit 22. Bits 63:32 of nanResult are then zero.
- R3: A NaN has an all-ones exponent and a non-zero mantissa. With legacyNan=1 it is signaling when the top mantissa bit is 1. With legacyNan=0 it is signaling when that bit is 0.
- R4: With legacyNan=1, any signaling NaN wins over a quiet NaN. Within each kind the search order is a, then b, then c.
- R5: With legacyNan=0, any signaling NaN wins over a quiet NaN. Within each kind the search order is c, then a, then b.
- R6: invalidOp is 1 when any operand is a signaling NaN. A result chosen only from quiet NaNs leaves invalidOp at 0.
- R7: The chosen operand is output quiet. With legacyNan=1 its top mantissa bit is cleared, and if that leaves the mantissa zero the default NaN is output instead. With legacyNan=0 its top mantissa bit is set.
- R8: With legacyNan=1, when one of a and b is infinity, the other is zero, and c is any NaN, the output is the default NaN and invalidOp is 1. This holds for either order of a and b.
- R9: With legacyNan=0, in the same infinity-times-zero-plus-NaN case, the output is c made quiet and invalidOp is 1. This holds for either order of a and b.
- R10: The legacy default NaN is 0x7FBFFFFF in single precision and 0x7FF7FFFFFFFFFFFF in double precision.
- R11: In double precision (isDouble=1) all 64 bits are examined: exponent bits 62:52, mantissa bits 51:0, quiet/signal bit 51. A pattern that is a NaN only as a single-precision value is then not a NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 64 | Multiplicand a |
| opB | input | 64 | Multiplier b |
| opC | input | 64 | Addend c |
| isDouble | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| legacyNan | input | 1 | 1 = legacy NaN convention, 0 = 2008 convention |
| nanPresent | output | 1 | The result is a NaN decided here |
| nanResult | output | 64 | The chosen quiet NaN, or zero when nanPresent is 0 |
| invalidOp | output | 1 | Invalid-operation exception request |

## Verification
The assertions assume that every input is a settled two-state value while they are evaluated. They also assume that legacyNan and isDouble change only together with the operands, so each check sees one consistent operand set. The stimulus meets this by driving all five inputs in the same step just after a clock edge and sampling half a period later. It never drives X or Z. The operand patterns cover the search orders, the quieting corner in which the payload becomes empty, both operand orders of infinity times zero, and upper-half bits that must be ignored in single precision.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;
  typedef struct packed {
    logic isNan;
    logic isSnan;
    logic isInf;
    logic isZero;
  } opClass_t;

  typedef enum logic [1:0] {
    PICK_A   = 2'd0,
    PICK_B   = 2'd1,
    PICK_C   = 2'd2,
    PICK_DEF = 2'd3
  } pick_e;

  typedef struct packed {
    pick_e pick;
    logic  raiseInvalid;
    logic  anyNan;
  } ctrlStrobe_t;
endpackage

// File: rtl/fmanan_classify.sv
module fmanan_classify
  import fmanan_pkg::*;
#(
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52,
  parameter int DW     = 64
) (
  input  logic [DW-1:0] op,
  input  logic          isDouble,
  input  logic          legacyNan,
  output opClass_t      cls
);
  logic expOnes, expZero, manZero, topBit;

  always_comb begin
    if (isDouble) begin
      expOnes = &op[DP_MAN +: DP_EXP];
      expZero = ~|op[DP_MAN +: DP_EXP];
      manZero = ~|op[DP_MAN-1:0];
      topBit  = op[DP_MAN-1];
    end else begin
      expOnes = &op[SP_MAN +: SP_EXP];
      expZero = ~|op[SP_MAN +: SP_EXP];
      manZero = ~|op[SP_MAN-1:0];
      topBit  = op[SP_MAN-1];
    end
    cls.isNan  = expOnes && !manZero;
    cls.isSnan = cls.isNan && (topBit == legacyNan);
    cls.isInf  = expOnes && manZero;
    cls.isZero = expZero && manZero;
  end

  always_comb begin
    AST_CLASS_EXCLUSIVE: assert ($onehot0({cls.isNan, cls.isInf, cls.isZero})) // R3
      else $error("operand classes overlap");
  end
endmodule

// File: rtl/fmanan_ctrl.sv
module fmanan_ctrl
  import fmanan_pkg::*;
(
  input  opClass_t    clsA,
  input  opClass_t    clsB,
  input  opClass_t    clsC,
  input  logic        legacyNan,
  output ctrlStrobe_t strobe
);
  opClass_t clsArr [3];
  pick_e    order  [3];
  logic     infZero, anySnan, found;

  assign clsArr[0] = clsA;
  assign clsArr[1] = clsB;
  assign clsArr[2] = clsC;

  always_comb begin
    if (legacyNan) begin
      order[0] = PICK_A; order[1] = PICK_B; order[2] = PICK_C;
    end else begin
      order[0] = PICK_C; order[1] = PICK_A; order[2] = PICK_B;
    end
  end

  always_comb begin
    infZero = ((clsA.isInf && clsB.isZero) || (clsA.isZero && clsB.isInf)) && clsC.isNan;
    anySnan = clsA.isSnan || clsB.isSnan || clsC.isSnan;
    strobe.anyNan       = clsA.isNan || clsB.isNan || clsC.isNan;
    strobe.raiseInvalid = anySnan || infZero;
    strobe.pick         = PICK_DEF;
    found               = 1'b0;
    if (infZero) begin
      strobe.pick = legacyNan ? PICK_DEF : PICK_C;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (!found && clsArr[order[i]].isSnan) begin
          strobe.pick = order[i];
          found = 1'b1;
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (!found && clsArr[order[i]].isNan) begin
          strobe.pick = order[i];
          found = 1'b1;
        end
      end
    end
  end

  logic pickedNan;
  always_comb begin
    case (strobe.pick)
      PICK_A:  pickedNan = clsA.isNan;
      PICK_B:  pickedNan = clsB.isNan;
      PICK_C:  pickedNan = clsC.isNan;
      default: pickedNan = 1'b1;
    endcase
    AST_PICK_IS_NAN: assert (!strobe.anyNan || pickedNan) // R4
      else $error("picked operand is not a NaN");
    AST_INVALID_NEEDS_NAN: assert (!strobe.raiseInvalid || strobe.anyNan) // R6
      else $error("invalid raised without a NaN operand");
    AST_DEFAULT_LEGACY_ONLY: assert (!(strobe.anyNan && strobe.pick == PICK_DEF) || legacyNan) // R9
      else $error("default NaN chosen in 2008 mode");
  end
endmodule

// File: rtl/fmanan_datapath.sv
module fmanan_datapath
  import fmanan_pkg::*;
#(
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52,
  parameter int DW     = 64
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] opC,
  input  logic          isDouble,
  input  logic          legacyNan,
  input  ctrlStrobe_t   strobe,
  output logic          nanPresent,
  output logic [DW-1:0] nanResult,
  output logic          invalidOp
);
  localparam int SP_W = 1 + SP_EXP + SP_MAN;
  localparam int DP_W = 1 + DP_EXP + DP_MAN;
  localparam logic [SP_W-1:0] SP_DEF = {1'b0, {SP_EXP{1'b1}}, 1'b0, {(SP_MAN-1){1'b1}}};
  localparam logic [DP_W-1:0] DP_DEF = {1'b0, {DP_EXP{1'b1}}, 1'b0, {(DP_MAN-1){1'b1}}};

  logic [DW-1:0] chosen, quiet;
  logic          emptyPayload;

  always_comb begin
    case (strobe.pick)
      PICK_A:  chosen = opA;
      PICK_B:  chosen = opB;
      PICK_C:  chosen = opC;
      default: chosen = '0;
    endcase
    quiet = chosen;
    if (isDouble) begin
      quiet[DP_MAN-1] = !legacyNan;
      emptyPayload    = ~|quiet[DP_MAN-1:0];
    end else begin
      quiet           = {{(DW-SP_W){1'b0}}, chosen[SP_W-1:0]};
      quiet[SP_MAN-1] = !legacyNan;
      emptyPayload    = ~|quiet[SP_MAN-1:0];
    end
    nanPresent = strobe.anyNan;
    invalidOp  = strobe.raiseInvalid;
    if (!strobe.anyNan)
      nanResult = '0;
    else if (strobe.pick == PICK_DEF || emptyPayload)
      nanResult = isDouble ? DW'(DP_DEF) : DW'(SP_DEF);
    else
      nanResult = quiet;
  end

  logic outNan, outQuiet;
  always_comb begin
    outNan   = isDouble ? (&nanResult[DP_MAN +: DP_EXP]) && (|nanResult[DP_MAN-1:0])
                        : (&nanResult[SP_MAN +: SP_EXP]) && (|nanResult[SP_MAN-1:0]);
    outQuiet = isDouble ? (nanResult[DP_MAN-1] != legacyNan) : (nanResult[SP_MAN-1] != legacyNan);
    AST_OUT_IS_NAN: assert (!nanPresent || outNan) // R7
      else $error("output is not a NaN");
    AST_OUT_IS_QUIET: assert (!nanPresent || outQuiet) // R3
      else $error("output NaN is signaling");
    AST_IDLE_ZERO: assert (nanPresent || (nanResult == '0 && !invalidOp)) // R1
      else $error("outputs active with no NaN");
    AST_SP_UPPER_ZERO: assert (isDouble || nanResult[DW-1:SP_W] == '0) // R2
      else $error("single result has upper bits set");
  end
endmodule

// File: rtl/fmanan_sel.sv
module fmanan_sel
  import fmanan_pkg::*;
#(
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52,
  parameter int DW     = 1 + DP_EXP + DP_MAN
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] opC,
  input  logic          isDouble,
  input  logic          legacyNan,
  output logic          nanPresent,
  output logic [DW-1:0] nanResult,
  output logic          invalidOp
);
  logic [DW-1:0] ops    [3];
  opClass_t      clsArr [3];
  ctrlStrobe_t   strobe;

  assign ops[0] = opA;
  assign ops[1] = opB;
  assign ops[2] = opC;

  for (genvar i = 0; i < 3; i++) begin : g_cls
    fmanan_classify #(
      .SP_EXP(SP_EXP), .SP_MAN(SP_MAN), .DP_EXP(DP_EXP), .DP_MAN(DP_MAN), .DW(DW)
    ) u_cls (
      .op(ops[i]), .isDouble(isDouble), .legacyNan(legacyNan), .cls(clsArr[i])
    );
  end

  fmanan_ctrl u_ctrl (
    .clsA(clsArr[0]), .clsB(clsArr[1]), .clsC(clsArr[2]),
    .legacyNan(legacyNan), .strobe(strobe)
  );

  fmanan_datapath #(
    .SP_EXP(SP_EXP), .SP_MAN(SP_MAN), .DP_EXP(DP_EXP), .DP_MAN(DP_MAN), .DW(DW)
  ) u_dp (
    .opA(opA), .opB(opB), .opC(opC), .isDouble(isDouble), .legacyNan(legacyNan),
    .strobe(strobe), .nanPresent(nanPresent), .nanResult(nanResult), .invalidOp(invalidOp)
  );
endmodule

// File: tb/sim_fmanan_sel.sv
module sim_fmanan_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [63:0] opA, opB, opC, nanResult;
  logic        isDouble, legacyNan, nanPresent, invalidOp;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  typedef struct {
    logic        expNan;
    logic [63:0] expRes;
    logic        expInv;
    string       tag;
  } item_t;
  item_t sbq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmanan_sel u0 (
    .opA(opA), .opB(opB), .opC(opC), .isDouble(isDouble), .legacyNan(legacyNan),
    .nanPresent(nanPresent), .nanResult(nanResult), .invalidOp(invalidOp)
  );

  task automatic drive(input logic [63:0] a, b, c, input logic dbl, leg,
                       input logic eNan, input logic [63:0] eRes, input logic eInv,
                       input string tag);
    item_t it;
    @(posedge clk);
    #1;
    opA = a; opB = b; opC = c; isDouble = dbl; legacyNan = leg;
    it.expNan = eNan; it.expRes = eRes; it.expInv = eInv; it.tag = tag;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (nanPresent !== it.expNan || nanResult !== it.expRes || invalidOp !== it.expInv) begin
        errors++;
        $display("FAIL %s: got nan=%b res=%h inv=%b, expected nan=%b res=%h inv=%b",
                 it.tag, nanPresent, nanResult, invalidOp, it.expNan, it.expRes, it.expInv);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] ONE_S = 64'h3F800000, INF_S = 64'h7F800000;
  localparam logic [63:0] INF_D = 64'h7FF0000000000000;

  initial begin
    opA = '0; opB = '0; opC = '0; isDouble = 0; legacyNan = 0;
    // R1 idle state and non-NaN cases
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R1 all zero");
    drive(INF_S, 0, ONE_S, 0, 0, 0, 0, 0, "R1 inf*0 with numeric addend");
    // R6 quiet NaN only, 2008 mode
    drive(64'h7FC00001, ONE_S, ONE_S, 0, 0, 1, 64'h7FC00001, 0, "R6 quiet a no invalid");
    // R5 2008 ordering c,a,b
    drive(64'h7F800003, ONE_S, 64'h7FC00007, 0, 0, 1, 64'h7FC00003, 1, "R5 sNaN a beats qNaN c");
    drive(64'h7FC00011, 64'h7FC00022, 64'h7FC00033, 0, 0, 1, 64'h7FC00033, 0, "R5 all quiet picks c");
    drive(64'h7F800011, 64'h7F800022, ONE_S, 0, 0, 1, 64'h7FC00011, 1, "R5 sNaN a before b");
    drive(ONE_S, 64'h7FC00022, ONE_S, 0, 0, 1, 64'h7FC00022, 0, "R5 lone quiet b");
    // R4 legacy ordering a,b,c
    drive(64'h7F800011, 64'h7F800022, 64'h7F800033, 0, 1, 1, 64'h7F800011, 0, "R4 all quiet picks a");
    drive(64'h7F800011, ONE_S, 64'h7FC00033, 0, 1, 1, 64'h7F800033, 1, "R4 sNaN c beats qNaN a");
    drive(ONE_S, 64'h7FC00022, 64'h7FC00033, 0, 1, 1, 64'h7F800022, 1, "R4 sNaN b before c");
    // R8 legacy inf*0+NaN, both orders
    drive(INF_S, 0, 64'h7F800033, 0, 1, 1, 64'h7FBFFFFF, 1, "R8 inf,zero,nan");
    drive(0, INF_S, 64'h7F800033, 0, 1, 1, 64'h7FBFFFFF, 1, "R8 zero,inf,nan");
    // R9 2008 inf*0+NaN returns c
    drive(INF_S, 0, 64'h7FC00033, 0, 0, 1, 64'h7FC00033, 1, "R9 inf,zero,qnan");
    drive(0, INF_S, 64'h7F800033, 0, 0, 1, 64'h7FC00033, 1, "R9 zero,inf,snan quieted");
    // R7 legacy quieting empties payload -> default
    drive(64'h7FC00000, ONE_S, ONE_S, 0, 1, 1, 64'h7FBFFFFF, 1, "R7 legacy empty payload");
    drive(64'h7FF8000000000000, 0, 0, 1, 1, 1, 64'h7FF7FFFFFFFFFFFF, 1, "R7 legacy empty payload dbl");
    // R11 double precision
    drive(64'h7FF0000000000005, 0, 0, 1, 0, 1, 64'h7FF8000000000005, 1, "R11 double sNaN quieted");
    drive(64'h000000007FC00001, 0, 0, 1, 0, 0, 0, 0, "R11 single NaN pattern in double");
    // R10 legacy double default
    drive(INF_D, 0, 64'h7FF0000000000007, 1, 1, 1, 64'h7FF7FFFFFFFFFFFF, 1, "R10 double legacy default");
    drive(0, INF_D, 64'h7FF8000000000009, 1, 0, 1, 64'h7FF8000000000009, 1, "R9 double 2008 returns c");
    // R2 single ignores upper half
    drive(64'hFFFFFFFF7FC00001, 0, 0, 0, 0, 1, 64'h000000007FC00001, 0, "R2 upper bits ignored");
    drive(64'h7FF8000000000000, 0, 0, 0, 0, 0, 0, 0, "R2 double NaN upper not seen in single");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule